// File: doc/BRIEF.md
# Multi-Source XOR Parity Accumulator

This block builds a parity stripe by XORing up to four equally sized source buffers together, 64 bits at a time. Software sets four source base addresses, a destination base address, a byte count and a small control word, then pulses `start`. The block makes one whole pass over each enabled source through a request/valid read port. Each returning word is folded into an on-chip queue of 128 64-bit entries, so up to 1024 bytes of parity are held on chip.

The block writes nothing until the last source pass has completed. Only then does it stream the queue contents to the destination through a valid/ready write port. A control bit marks those writes as bound for an external target rather than local memory, so a downstream router can steer them. Sources are always read from the local read port.

Top module: `xor_parity_acc`

## Requirements
- R1: Bit i of `ctrl[3:0]` enables source i. Enabled sources are read one whole pass at a time in ascending index order, each pass at addresses base+8k for k = 0 up to words-1 in ascending order. A disabled source is never read.
- R2: Parity word k is the XOR of word k of every enabled source, and it is written to `dst_addr`+8k. Writes occur in ascending k.
- R3: The first enabled pass loads the queue directly. Nothing left from an earlier operation reaches the result, so a single enabled source produces an exact copy.
- R4: A byte count of 1024 fills the queue exactly. All 128 words are read from each source and all 128 words are written.
- R5: No destination write is issued before every read of every pass has returned its data.
- R6: `ctrl[4]` = 1 drives `wr_ext` high on every destination write. `ctrl[4]` = 0 keeps it low.
- R7: A start with a byte count that is zero, not a multiple of 8, or above 1024, or with `ctrl[3:0]` = 0, sets `err` and issues no reads or writes, and `busy` stays low. The next valid start clears `err`.
- R8: `busy` is high from the cycle after an accepted start through the handshake of the last destination write. `done` is then high for exactly one cycle, with `busy` low.
- R9: While `rd_req_ready` or `wr_ready` is low, the pending request holds its valid, address and data, and no data is lost or repeated.
- R10: After reset, `busy`, `done`, `err`, `rd_req_valid` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation using the programmed values (used only when idle) |
| src_addr0 | input | 32 | Base byte address of source 0 |
| src_addr1 | input | 32 | Base byte address of source 1 |
| src_addr2 | input | 32 | Base byte address of source 2 |
| src_addr3 | input | 32 | Base byte address of source 3 |
| dst_addr | input | 32 | Base byte address of the parity destination |
| byte_cnt | input | 16 | Length of every buffer in bytes |
| ctrl | input | 5 | [3:0] source enables, [4] external destination |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read port accepts the request |
| rd_req_addr | output | 32 | Read request byte address |
| rd_data_valid | input | 1 | Read data returned, in request order |
| rd_data | input | 64 | Returned read data |
| wr_valid | output | 1 | Destination write valid |
| wr_ready | input | 1 | Write port accepts the write |
| wr_addr | output | 32 | Destination write byte address |
| wr_data | output | 64 | Destination write data |
| wr_ext | output | 1 | Write is steered to the external target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected |

## Verification
The assertions assume that the read port returns data strictly in request order, and only for requests it has accepted. `rd_data_valid` is therefore never high while the block has no read outstanding. The bench memory model answers each accepted request exactly once, one cycle later, so it never volunteers data. The model also holds `rd_data_valid` low while reset is applied. On stalled runs the model toggles both ready signals from a pseudo-random sequence, but it never changes the programmed inputs while an operation is in flight.

// File: rtl/xpa_pkg.sv
// Package: shared types for the XOR parity accumulator.
// Assumes: nothing beyond SystemVerilog 2017.
package xpa_pkg;
    localparam int NSRC = 4;  // number of source address inputs on the top

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xpa_state_e;
endpackage

// File: rtl/xpa_cfg.sv
// Module: xpa_cfg
// Checks a requested byte count and source-enable mask, and gives the
// length in datapath words.
// Assumes: OFS_W + CNT_W <= BCNT_W, so the word count is a slice of the byte count.
module xpa_cfg #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    parameter int BCNT_W = 16,
    parameter int NSRC   = 4
) (
    input  logic [BCNT_W-1:0]          byte_cnt,
    input  logic [NSRC-1:0]            src_en,
    output logic                       cfg_ok,
    output logic [$clog2(DEPTH):0]     nwords
);
    localparam int BYTES_W   = DATA_W / 8;
    localparam int OFS_W     = $clog2(BYTES_W);
    localparam int CNT_W     = $clog2(DEPTH) + 1;
    localparam int MAX_BYTES = DEPTH * BYTES_W;

    // Validate the length and mask, and convert bytes to words.
    always_comb begin
        cfg_ok = (byte_cnt != '0)
              && (byte_cnt[OFS_W-1:0] == '0)
              && (byte_cnt <= BCNT_W'(MAX_BYTES))
              && (src_en != '0);
        nwords = byte_cnt[OFS_W +: CNT_W];
    end
endmodule

// File: rtl/xpa_srcsel.sv
// Module: xpa_srcsel
// Finds the lowest enabled source, either from scratch or strictly above
// the current one.
// Assumes: NSRC <= 2**SEL_W.
module xpa_srcsel #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSRC-1:0]  en,
    input  logic [SEL_W-1:0] cur,
    input  logic             from_start,
    output logic             found,
    output logic [SEL_W-1:0] idx
);
    // Scan downward so that the last hit is the lowest qualifying index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (en[i] && (from_start || (i > int'(cur)))) begin
                found = 1'b1;
                idx   = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/xpa_queue.sv
// Module: xpa_queue
// Accumulation store: each write either loads an entry or XORs into it.
// The read port is combinational.
// Assumes: wr_idx and rd_idx are below DEPTH. The storage has no reset,
// because the first pass of every operation overwrites it.
module xpa_queue #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              load,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Load on the first pass, accumulate by XOR afterwards.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= load ? wr_data : (mem[wr_idx] ^ wr_data);
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/xor_parity_acc.sv
// Module: xor_parity_acc (top)
// Sequences whole-buffer read passes over the enabled sources, folding
// each returned word into the queue. After the final pass it writes the
// queue contents to the destination.
// Assumes: read data returns in request order, and only for accepted
// requests. The write port may stall at any time.
module xor_parity_acc #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 128,
    parameter int BCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr0,
    input  logic [ADDR_W-1:0] src_addr1,
    input  logic [ADDR_W-1:0] src_addr2,
    input  logic [ADDR_W-1:0] src_addr3,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [BCNT_W-1:0] byte_cnt,
    input  logic [4:0]        ctrl,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_data_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_ext,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import xpa_pkg::*;

    localparam int SEL_W = $clog2(NSRC);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int OFS_W = $clog2(DATA_W / 8);

    xpa_state_e        state;
    logic [ADDR_W-1:0] src_in     [NSRC];
    logic [ADDR_W-1:0] src_base_r [NSRC];
    logic [ADDR_W-1:0] dst_base_r;
    logic [NSRC-1:0]   en_r;
    logic              ext_r;
    logic [CNT_W-1:0]  nwords_r;
    logic [SEL_W-1:0]  cur_src;
    logic              first_pass;
    logic [CNT_W-1:0]  req_idx;
    logic [CNT_W-1:0]  ret_idx;
    logic [CNT_W-1:0]  wout_idx;
    logic              done_r;
    logic              err_r;

    logic              cfg_ok;
    logic [CNT_W-1:0]  cfg_nwords;
    logic              first_found;
    logic [SEL_W-1:0]  first_idx;
    logic              next_found;
    logic [SEL_W-1:0]  next_idx;
    logic [DATA_W-1:0] q_rd;
    logic              data_fire;
    logic              last_ret;
    logic              wr_fire;

    assign src_in[0] = src_addr0;
    assign src_in[1] = src_addr1;
    assign src_in[2] = src_addr2;
    assign src_in[3] = src_addr3;

    xpa_cfg #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BCNT_W(BCNT_W), .NSRC(NSRC)) u_cfg (
        .byte_cnt (byte_cnt),
        .src_en   (ctrl[NSRC-1:0]),
        .cfg_ok   (cfg_ok),
        .nwords   (cfg_nwords)
    );

    xpa_srcsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_first (
        .en         (ctrl[NSRC-1:0]),
        .cur        ('0),
        .from_start (1'b1),
        .found      (first_found),
        .idx        (first_idx)
    );

    xpa_srcsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_next (
        .en         (en_r),
        .cur        (cur_src),
        .from_start (1'b0),
        .found      (next_found),
        .idx        (next_idx)
    );

    xpa_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_queue (
        .clk     (clk),
        .wr_en   (data_fire),
        .load    (first_pass),
        .wr_idx  (ret_idx[IDX_W-1:0]),
        .wr_data (rd_data),
        .rd_idx  (wout_idx[IDX_W-1:0]),
        .rd_data (q_rd)
    );

    // Port-side handshake and address generation.
    always_comb begin
        rd_req_valid = (state == ST_READ) && (req_idx < nwords_r);
        rd_req_addr  = src_base_r[cur_src] + ADDR_W'({req_idx, {OFS_W{1'b0}}});
        wr_valid     = (state == ST_WRITE);
        wr_addr      = dst_base_r + ADDR_W'({wout_idx, {OFS_W{1'b0}}});
        wr_data      = q_rd;
        wr_ext       = ext_r && (state == ST_WRITE);
        data_fire    = (state == ST_READ) && rd_data_valid;
        last_ret     = data_fire && (ret_idx == nwords_r - 1'b1);
        wr_fire      = wr_valid && wr_ready;
    end

    // Main sequencer: accept start, run the read passes, then the write-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            dst_base_r <= '0;
            en_r       <= '0;
            ext_r      <= 1'b0;
            nwords_r   <= '0;
            cur_src    <= '0;
            first_pass <= 1'b0;
            req_idx    <= '0;
            ret_idx    <= '0;
            wout_idx   <= '0;
            done_r     <= 1'b0;
            err_r      <= 1'b0;
            for (int i = 0; i < NSRC; i++) src_base_r[i] <= '0;
        end else begin
            done_r <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && cfg_ok && first_found) begin
                        for (int i = 0; i < NSRC; i++) src_base_r[i] <= src_in[i];
                        dst_base_r <= dst_addr;
                        en_r       <= ctrl[NSRC-1:0];
                        ext_r      <= ctrl[NSRC];
                        nwords_r   <= cfg_nwords;
                        cur_src    <= first_idx;
                        first_pass <= 1'b1;
                        req_idx    <= '0;
                        ret_idx    <= '0;
                        err_r      <= 1'b0;
                        state      <= ST_READ;
                    end else if (start) begin
                        err_r <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (rd_req_valid && rd_req_ready) req_idx <= req_idx + 1'b1;
                    if (data_fire) ret_idx <= ret_idx + 1'b1;
                    if (last_ret) begin
                        req_idx <= '0;
                        ret_idx <= '0;
                        if (next_found) begin
                            cur_src    <= next_idx;
                            first_pass <= 1'b0;
                        end else begin
                            wout_idx <= '0;
                            state    <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_fire) begin
                        if (wout_idx == nwords_r - 1'b1) begin
                            state  <= ST_IDLE;
                            done_r <= 1'b1;
                        end else begin
                            wout_idx <= wout_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = done_r;
    assign err  = err_r;

    // Guards on handshakes, completion and input assumptions.
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(wr_valid && wr_ready)); // R8
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !rd_req_valid && !wr_valid); // R7
    AST_DATA_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_valid |-> (state == ST_READ) && (ret_idx < req_idx)); // R9
    AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(rd_data_valid)); // R5
endmodule

// File: tb/xor_parity_acc_tb.sv
module xor_parity_acc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr0, src_addr1, src_addr2, src_addr3, dst_addr;
    logic [15:0] byte_cnt = '0;
    logic [4:0]  ctrl = '0;
    logic        rd_req_valid, rd_req_ready;
    logic [31:0] rd_req_addr;
    logic        rd_data_valid;
    logic [63:0] rd_data;
    logic        wr_valid, wr_ready;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic        wr_ext, busy, done, err;

    int errors = 0;
    int checks = 0;

    // Bench memory model state
    logic        clr = 1'b0;
    logic        stall = 1'b0;
    logic        exp_ext = 1'b0;
    int          exp_reads = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] rdlog [512];
    logic [63:0] cap [128];
    int          rd_n, ret_n, wr_n, done_n;
    logic        ext_bad, busy_bad, early_bad;

    always #4 clk = ~clk;

    xor_parity_acc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr0(src_addr0), .src_addr1(src_addr1),
        .src_addr2(src_addr2), .src_addr3(src_addr3),
        .dst_addr(dst_addr), .byte_cnt(byte_cnt), .ctrl(ctrl),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_data_valid(rd_data_valid),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ext(wr_ext),
        .busy(busy), .done(done), .err(err)
    );

    function automatic logic [63:0] memf(input logic [31:0] a);
        return {a ^ 32'h5A5A_1234, (a * 32'h9E37_79B9) + 32'h0137_C0DE};
    endfunction

    function automatic logic [31:0] src_of(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0000;
    endfunction

    // Memory model: one-cycle read latency, random ready when stalling,
    // and capture of every write and read.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_data_valid <= 1'b0;
            rd_data       <= '0;
            rd_req_ready  <= 1'b1;
            wr_ready      <= 1'b1;
            rd_n <= 0; ret_n <= 0; wr_n <= 0; done_n <= 0;
            ext_bad <= 1'b0; busy_bad <= 1'b0; early_bad <= 1'b0;
        end else begin
            lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_req_ready  <= stall ? lfsr[0] : 1'b1;
            wr_ready      <= stall ? lfsr[5] : 1'b1;
            rd_data_valid <= rd_req_valid && rd_req_ready;
            rd_data       <= memf(rd_req_addr);
            if (rd_req_valid && rd_req_ready) begin
                if (rd_n < 512) rdlog[rd_n] <= rd_req_addr;
                rd_n <= rd_n + 1;
            end
            if (rd_data_valid) ret_n <= ret_n + 1;
            if (done) done_n <= done_n + 1;
            if (wr_valid && wr_ready) begin
                if (((wr_addr - dst_addr) >> 3) < 128)
                    cap[(wr_addr - dst_addr) >> 3] <= wr_data;
                wr_n <= wr_n + 1;
                if (wr_ext !== exp_ext) ext_bad <= 1'b1;
                if (!busy) busy_bad <= 1'b1;
                if (ret_n + (rd_data_valid ? 1 : 0) != exp_reads) early_bad <= 1'b1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Launch one operation and wait for done (returns 0 on timeout).
    task automatic launch(input logic [4:0] c, input logic [15:0] n, output logic ok);
        ctrl = c; byte_cnt = n; start = 1'b1;
        @(negedge clk); start = 1'b0;
        ok = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Full run with checks of reads, parity, ordering and flags.
    task automatic run_and_check(input string tag, input logic [4:0] c,
                                 input logic [15:0] n, input logic st);
        logic ok;
        int   nw, j, bad_rd, bad_wd;
        logic [63:0] e;
        nw = n / 8;
        stall = st; exp_ext = c[4];
        exp_reads = nw * $countones(c[3:0]);
        clear_model();
        launch(c, n, ok);
        chk(ok, "R8", {tag, " done seen"}, 64'(ok), 1);
        if (!ok) return;
        chk(!busy, "R8", {tag, " busy low with done"}, 64'(busy), 0);
        @(negedge clk);
        chk(!done && done_n == 1, "R8", {tag, " done one cycle"}, 64'(done_n), 1);
        chk(!busy_bad, "R8", {tag, " busy through writes"}, 64'(busy_bad), 0);
        // R1: read order and coverage
        chk(rd_n == exp_reads, "R1", {tag, " read count"}, 64'(rd_n), 64'(exp_reads));
        bad_rd = 0; j = 0;
        for (int s = 0; s < 4; s++) begin
            if (c[s]) begin
                for (int k = 0; k < nw; k++) begin
                    if (j < 512 && rdlog[j] !== src_of(s) + 32'(8 * k)) bad_rd++;
                    j++;
                end
            end
        end
        chk(bad_rd == 0, "R1", {tag, " read addresses/order"}, 64'(bad_rd), 0);
        // R2 / R4: parity contents and write count
        chk(wr_n == nw, "R4", {tag, " write count"}, 64'(wr_n), 64'(nw));
        bad_wd = 0;
        for (int k = 0; k < nw; k++) begin
            e = '0;
            for (int s = 0; s < 4; s++)
                if (c[s]) e ^= memf(src_of(s) + 32'(8 * k));
            if (cap[k] !== e) begin
                if (bad_wd == 0)
                    chk(1'b0, "R2", {tag, " parity word"}, cap[k], e);
                bad_wd++;
            end
        end
        chk(bad_wd == 0, "R2", {tag, " parity mismatches"}, 64'(bad_wd), 0);
        chk(!early_bad, "R5", {tag, " writes after all reads"}, 64'(early_bad), 0);
        chk(!ext_bad, "R6", {tag, " wr_ext value"}, 64'(ext_bad), 0);
        chk(!err, "R7", {tag, " err clear after valid start"}, 64'(err), 0);
    endtask

    task automatic test_reset();
        chk(!busy && !done && !err, "R10", "flags after reset", {61'd0, busy, done, err}, 0);
        chk(!rd_req_valid && !wr_valid, "R10", "ports idle after reset",
            {62'd0, rd_req_valid, wr_valid}, 0);
    endtask

    task automatic test_full();      // R1 R2 R4 R5 R6 R8
        run_and_check("full4", 5'b0_1111, 16'd1024, 1'b0);
    endtask

    task automatic test_subset();    // R1 R2 R6 R9 with stalls
        run_and_check("subset", 5'b1_1010, 16'd64, 1'b1);
    endtask

    task automatic test_single();    // R3: copy, no stale queue content
        run_and_check("single", 5'b0_0100, 16'd256, 1'b1);
    endtask

    task automatic test_bad(input string tag, input logic [4:0] c, input logic [15:0] n);
        logic sawbusy;
        stall = 1'b0;
        clear_model();
        ctrl = c; byte_cnt = n; start = 1'b1;
        @(negedge clk); start = 1'b0;
        sawbusy = 1'b0;
        for (int t = 0; t < 20; t++) begin
            if (busy) sawbusy = 1'b1;
            @(negedge clk);
        end
        chk(err, "R7", {tag, " err set"}, 64'(err), 1);
        chk(!sawbusy && rd_n == 0 && wr_n == 0, "R7", {tag, " no activity"},
            64'(rd_n + wr_n + int'(sawbusy)), 0);
    endtask

    initial begin
        src_addr0 = src_of(0); src_addr1 = src_of(1);
        src_addr2 = src_of(2); src_addr3 = src_of(3);
        dst_addr  = 32'h2000_0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_full();
        test_subset();
        test_single();
        test_bad("zero", 5'b0_1111, 16'd0);
        test_bad("unaligned", 5'b0_1111, 16'd12);
        test_bad("too long", 5'b0_0011, 16'd1032);
        test_bad("no sources", 5'b1_0000, 16'd64);
        run_and_check("recover", 5'b0_1001, 16'd8, 1'b0);   // R7 clear, one word
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule